// File: doc/BRIEF.md
# Variable-length byte-coded processor core

This block is a small multi-cycle processor that runs programs out of a 256-byte store holding both code and data. It has four 8-bit program registers, which software can name, and a hidden program counter and instruction register, which it cannot. Every instruction starts with one byte whose top three bits pick one of eight operations. A literal load and a conditional jump carry a second byte. All other operations fit in the first byte alone. Each instruction takes two enabled clock cycles. The first cycle captures the opcode byte. The second cycle reads any second byte or data operand, performs the operation, and moves the program counter on.

The surrounding logic preloads a program through a byte-wide side port while the core is held in reset, releases reset, and raises the run input. The run input pauses the core whenever it is low. The core stops by itself and raises its halt output when control would run past the highest address. The four registers are visible on a flat output bus, and the side port can read any byte of the store back at any time.

Top module: `byte_accum_cpu`

## Requirements
- R1: A synchronous active-low reset clears the program counter, the instruction register, all four registers and the halt flag. It leaves the byte store unchanged.
- R2: The opcode is bits 7:5 of the first byte. Codes 000 and 001 are two bytes long and all others are one byte long. The program counter advances by the length. Each instruction uses two enabled cycles: a register result is visible after the second rising edge and not after the first.
- R3: Opcode 000 writes the second byte into the register selected by bits 3:2.
- R4: Opcode 001 tests the register selected by bits 1:0. If that register is nonzero, control goes to the address in the second byte. Otherwise control goes to the current address plus 2.
- R5: Opcodes 100, 101 and 110 compute a = a + b, a = a - b and a = a × b, where a is the register in bits 3:2 and b is the register in bits 1:0. Results wrap modulo 256, and the product keeps its low 8 bits.
- R6: Opcode 111 sets register a to 1 when a < b as unsigned values, and to 0 otherwise.
- R7: Opcode 010 loads register[bits 3:2] from the byte addressed by register[bits 1:0]. Opcode 011 writes register[bits 1:0] to the byte addressed by register[bits 3:2] and changes no register.
- R8: Bit 4 of the first byte has no effect on any operation.
- R9: The core raises halt and keeps it, with registers and store frozen, until reset, in either of two cases. In the first, an executed instruction would move the program counter past address 255. In the second, a two-byte instruction sits at address 255; that instruction is not executed.
- R10: While run is low, the core's state does not change. Raising run again resumes execution where it stopped.
- R11: The side port writes a byte on a clock edge when its write enable is high and reads any byte combinationally. When it writes in the same cycle as a store by the core, both writes take effect if the addresses differ. If the addresses are the same, the side-port byte wins.
- R12: A squaring loop that starts from 3 and repeats while the value is below 50 finishes with 81 (0x51) in r0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| run_i | input | 1 | Execution enable; the core pauses when low |
| dbg_we_i | input | 1 | Side-port write enable for the byte store |
| dbg_addr_i | input | 8 | Side-port byte address for reads and writes |
| dbg_wdata_i | input | 8 | Side-port write byte |
| dbg_rdata_o | output | 8 | Byte stored at dbg_addr_i |
| halted_o | output | 1 | High once the core has stopped, until reset |
| regs_o | output | 32 | Registers r3..r0 packed, with r0 in bits 7:0 |

## Verification
A store executed by the core and a side-port write can land on the byte store in the same clock edge. This is the one place where two functions meet in a single cycle. The bench preloads a short program whose store instruction executes on the sixth enabled edge after run rises. It drives a side-port write timed to that same edge, first to the address the store targets and then to a neighbouring address. It reads both bytes back after the core has halted. The same-address case must leave the side-port value, and the split case must leave both values.

// File: rtl/bac_pkg.sv
`timescale 1ns/1ps
// Shared constants, opcode and phase types, and instruction-byte layout
// for the byte-coded core. Assumes 8-bit data, 8-bit addresses, four registers.
package bac_pkg;
    localparam int WORD_W   = 8;
    localparam int ADR_W    = 8;
    localparam int NUM_REGS = 4;

    typedef enum logic [2:0] {
        OP_LIT   = 3'd0,
        OP_JNZ   = 3'd1,
        OP_LOAD  = 3'd2,
        OP_STORE = 3'd3,
        OP_ADD   = 3'd4,
        OP_SUB   = 3'd5,
        OP_MUL   = 3'd6,
        OP_LTU   = 3'd7
    } op_e;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    // First instruction byte: opcode, an ignored bit, written/read register fields
    typedef struct packed {
        op_e        op;
        logic       spare;
        logic [1:0] dst;
        logic [1:0] src;
    } instr_t;

    // True for the opcodes that carry a second byte
    function automatic logic is_wide(op_e op);
        return (op == OP_LIT) || (op == OP_JNZ);
    endfunction

    // True for the opcodes that write a program register
    function automatic logic writes_reg(op_e op);
        return (op != OP_JNZ) && (op != OP_STORE);
    endfunction
endpackage

// File: rtl/bac_alu.sv
`timescale 1ns/1ps
// Combinational arithmetic unit: add, subtract, low-half multiply and
// unsigned less-than, all wrapping at the word width.
// Assumes the caller selects its output only for the arithmetic opcodes.
module bac_alu
    import bac_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  op_e          op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    // Result select by opcode
    always_comb begin
        unique case (op_i)
            OP_ADD:  y_o = a_i + b_i;
            OP_SUB:  y_o = a_i - b_i;
            OP_MUL:  y_o = a_i * b_i;
            OP_LTU:  y_o = (a_i < b_i) ? W'(1) : '0;
            default: y_o = '0;
        endcase
    end

    // Output checks next to the operators they guard
    always_comb begin
        if (op_i == OP_SUB) begin
            p_sub_inverse_r5: assert (W'(y_o + b_i) == a_i);
        end
        if (op_i == OP_MUL) begin
            p_mul_parity_r5: assert (y_o[0] == (a_i[0] & b_i[0]));
        end
        if (op_i == OP_LTU) begin
            p_ltu_boolean_r6: assert (y_o <= W'(1));
        end
    end
endmodule

// File: rtl/bac_regfile.sv
`timescale 1ns/1ps
// Program register file: N words, one write port, two read ports and a flat
// observation bus. Assumes N is a power of two; reset clears every word.
module bac_regfile #(
    parameter  int W  = 8,
    parameter  int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [IW-1:0] widx_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [IW-1:0] ridx_a_i,
    output logic [W-1:0]  rdata_a_o,
    input  logic [IW-1:0] ridx_b_i,
    output logic [W-1:0]  rdata_b_o,
    output logic [N*W-1:0] flat_o
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_word
            logic [W-1:0] word_q;

            // Holds one register; clears on reset, loads when addressed
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (we_i && (widx_i == IW'(g))) begin
                    word_q <= wdata_i;
                end
            end

            assign flat_o[g*W +: W] = word_q;
        end
    endgenerate

    assign rdata_a_o = flat_o[ridx_a_i*W +: W];
    assign rdata_b_o = flat_o[ridx_b_i*W +: W];

    p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(flat_o));
endmodule

// File: rtl/bac_mem.sv
`timescale 1ns/1ps
// Unified byte store for code and data. One core read port, one core write
// port, and a side port with its own write and combinational read.
// Assumes no reset of the contents; on a shared write address the side port wins.
module bac_mem #(
    parameter  int W     = 8,
    parameter  int AW    = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_addr_i,
    output logic [W-1:0]  cpu_rdata_o,
    input  logic          cpu_we_i,
    input  logic [AW-1:0] cpu_waddr_i,
    input  logic [W-1:0]  cpu_wdata_i,
    input  logic          dbg_we_i,
    input  logic [AW-1:0] dbg_addr_i,
    input  logic [W-1:0]  dbg_wdata_i,
    output logic [W-1:0]  dbg_rdata_o
);
    logic [W-1:0] cells [DEPTH];

    // Two write ports; the side port is applied last so it wins a tie
    always_ff @(posedge clk) begin
        if (cpu_we_i) begin
            cells[cpu_waddr_i] <= cpu_wdata_i;
        end
        if (dbg_we_i) begin
            cells[dbg_addr_i] <= dbg_wdata_i;
        end
    end

    assign cpu_rdata_o = cells[cpu_addr_i];
    assign dbg_rdata_o = cells[dbg_addr_i];

    p_side_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_we_i && cpu_we_i && (dbg_addr_i == cpu_waddr_i))
        |=> (cells[$past(dbg_addr_i)] == $past(dbg_wdata_i)));

    p_store_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we_i && !(dbg_we_i && (dbg_addr_i == cpu_waddr_i)))
        |=> (cells[$past(cpu_waddr_i)] == $past(cpu_wdata_i)));
endmodule

// File: rtl/bac_seq.sv
`timescale 1ns/1ps
// Two-phase sequencer: holds PC, IR, phase and halt flag, computes the next
// PC (length step or jump), and stops at the top of the address space.
// Assumes mem_byte_i carries the byte at PC in fetch and at PC+1 in execute
// for two-byte opcodes, and that W equals AW so a byte is a full address.
module bac_seq
    import bac_pkg::*;
#(
    parameter int AW = ADR_W,
    parameter int W  = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [W-1:0]  mem_byte_i,
    input  logic          jump_hit_i,
    output instr_t        ir_o,
    output logic [AW-1:0] pc_o,
    output phase_e        phase_o,
    output logic          exec_o,
    output logic          halted_o
);
    localparam logic [AW-1:0] PC_LAST = '1;

    instr_t        ir_q;
    logic [AW-1:0] pc_q;
    phase_e        ph_q;
    logic          halt_q;

    logic        active;
    logic        wide;
    logic        top_stop;
    logic        taken;
    logic [AW:0] step_pc;
    logic [AW:0] next_pc;

    // Next-PC and execute-enable decode
    always_comb begin
        active   = run_i && !halt_q;
        wide     = is_wide(ir_q.op);
        top_stop = wide && (pc_q == PC_LAST);
        taken    = (ir_q.op == OP_JNZ) && jump_hit_i;
        step_pc  = {1'b0, pc_q} + (wide ? (AW+1)'(2) : (AW+1)'(1));
        next_pc  = taken ? {1'b0, AW'(mem_byte_i)} : step_pc;
        exec_o   = active && (ph_q == PH_EXEC) && !top_stop;
    end

    // Phase, IR, PC and halt state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q   <= instr_t'('0);
            pc_q   <= '0;
            ph_q   <= PH_FETCH;
            halt_q <= 1'b0;
        end else if (active) begin
            if (ph_q == PH_FETCH) begin
                ir_q <= instr_t'(mem_byte_i);
                ph_q <= PH_EXEC;
            end else begin
                ph_q <= PH_FETCH;
                if (top_stop || next_pc[AW]) begin
                    halt_q <= 1'b1;
                end else begin
                    pc_q <= next_pc[AW-1:0];
                end
            end
        end
    end

    assign ir_o     = ir_q;
    assign pc_o     = pc_q;
    assign phase_o  = ph_q;
    assign halted_o = halt_q;

    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt_q |=> halt_q);

    p_halt_freezes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt_q |=> ($stable(pc_q) && $stable(ir_q)));

    p_halt_from_exec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_q) |-> ($past(ph_q) == PH_EXEC));

    p_pause_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> ($stable(pc_q) && $stable(ph_q) && $stable(ir_q)));

    p_fetch_then_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (ph_q == PH_FETCH)) |=> (ph_q == PH_EXEC));
endmodule

// File: rtl/byte_accum_cpu.sv
`timescale 1ns/1ps
// Top of the byte-coded core: wires sequencer, register file, arithmetic unit
// and byte store, and steers the store address and register write data.
// Assumes the side port is used for preload and inspection only.
module byte_accum_cpu
    import bac_pkg::*;
#(
    parameter int DATA_W    = WORD_W,
    parameter int ADDR_W    = ADR_W,
    parameter int REG_COUNT = NUM_REGS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run_i,
    input  logic                        dbg_we_i,
    input  logic [ADDR_W-1:0]           dbg_addr_i,
    input  logic [DATA_W-1:0]           dbg_wdata_i,
    output logic [DATA_W-1:0]           dbg_rdata_o,
    output logic                        halted_o,
    output logic [REG_COUNT*DATA_W-1:0] regs_o
);
    instr_t            ir;
    logic [ADDR_W-1:0] pc;
    phase_e            phase;
    logic              exec;
    logic [DATA_W-1:0] dst_val;
    logic [DATA_W-1:0] src_val;
    logic [DATA_W-1:0] mem_rdata;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] alu_y;
    logic [DATA_W-1:0] rf_wdata;
    logic              rf_we;
    logic              st_we;
    logic              spare_unused;

    // Bit 4 of the opcode byte carries no meaning
    assign spare_unused = ir.spare;

    bac_seq #(
        .AW (ADDR_W),
        .W  (DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_i),
        .mem_byte_i (mem_rdata),
        .jump_hit_i (src_val != '0),
        .ir_o       (ir),
        .pc_o       (pc),
        .phase_o    (phase),
        .exec_o     (exec),
        .halted_o   (halted_o)
    );

    // Core read address: opcode, second byte, or load address
    always_comb begin
        if (phase == PH_FETCH) begin
            mem_addr = pc;
        end else if (is_wide(ir.op)) begin
            mem_addr = pc + ADDR_W'(1);
        end else begin
            mem_addr = ADDR_W'(src_val);
        end
    end

    // Register write data and enables for register and store writes
    always_comb begin
        rf_wdata = ((ir.op == OP_LIT) || (ir.op == OP_LOAD)) ? mem_rdata : alu_y;
        rf_we    = exec && writes_reg(ir.op);
        st_we    = exec && (ir.op == OP_STORE);
    end

    bac_regfile #(
        .W (DATA_W),
        .N (REG_COUNT)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (rf_we),
        .widx_i    (ir.dst),
        .wdata_i   (rf_wdata),
        .ridx_a_i  (ir.dst),
        .rdata_a_o (dst_val),
        .ridx_b_i  (ir.src),
        .rdata_b_o (src_val),
        .flat_o    (regs_o)
    );

    bac_alu #(
        .W (DATA_W)
    ) u_alu (
        .op_i (ir.op),
        .a_i  (dst_val),
        .b_i  (src_val),
        .y_o  (alu_y)
    );

    bac_mem #(
        .W  (DATA_W),
        .AW (ADDR_W)
    ) u_mem (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_addr_i  (mem_addr),
        .cpu_rdata_o (mem_rdata),
        .cpu_we_i    (st_we),
        .cpu_waddr_i (ADDR_W'(dst_val)),
        .cpu_wdata_i (src_val),
        .dbg_we_i    (dbg_we_i),
        .dbg_addr_i  (dbg_addr_i),
        .dbg_wdata_i (dbg_wdata_i),
        .dbg_rdata_o (dbg_rdata_o)
    );

    p_jump_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && (ir.op == OP_JNZ) && (src_val != '0)) |=> (pc == ADDR_W'($past(mem_rdata))));

    p_store_keeps_regs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && (ir.op == OP_STORE)) |=> $stable(regs_o));
endmodule

// File: tb/byte_accum_cpu_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a table of programs with expected register images,
// then directed tests for reset, pause, address-ceiling halts and
// same-cycle store and side-port writes.
module byte_accum_cpu_tb;
    localparam int NV       = 6;
    localparam int WD_LIMIT = 150000;

    typedef struct packed {
        logic [127:0] prog;
        logic [31:0]  regs;
    } vec_t;

    // Programs start at address 0, first byte in bits 127:120; regs = {r3,r2,r1,r0}
    localparam vec_t VECS [NV] = '{
        '{128'h00030432_C0080088_E922040C_0123FF00, 32'h01003251},
        '{128'h00051407_A1180999_0C0123FF_00000000, 32'h011007FE},
        '{128'h0014040D_C108030C_02EBED23_FF000000, 32'h01000D04},
        '{128'h0080045A_61480C01_4F23FF00_00000000, 32'h805A5A80},
        '{128'h00002009_04110C01_23FF0000_00000000, 32'h01001100},
        '{128'h0C012306_00770422_23FF0000_00000000, 32'h01002200}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run;
    logic        dbg_we;
    logic [7:0]  dbg_addr;
    logic [7:0]  dbg_wdata;
    logic [7:0]  dbg_rdata;
    logic        halted;
    logic [31:0] regs;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #10 clk = ~clk;

    byte_accum_cpu u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .dbg_we_i    (dbg_we),
        .dbg_addr_i  (dbg_addr),
        .dbg_wdata_i (dbg_wdata),
        .dbg_rdata_o (dbg_rdata),
        .halted_o    (halted),
        .regs_o      (regs)
    );

    function automatic string vtag(input int v);
        case (v)
            0:       return "R12 squaring loop";
            1:       return "R5 R8 wrap and ignored bit";
            2:       return "R5 R6 multiply and compare";
            3:       return "R7 store then load";
            4:       return "R4 jump not taken";
            default: return "R4 R3 jump taken skips literal";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        dbg_we = 1'b1; dbg_addr = a; dbg_wdata = d;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        dbg_addr = a;
        #1 d = dbg_rdata;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        run = 1'b0; rst_n = 1'b0;
    endtask

    task automatic free_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load_prog(input logic [127:0] p);
        for (int i = 0; i < 16; i++) poke(8'(i), p[127-8*i -: 8]);
        poke(8'hFF, 8'h00);
    endtask

    task automatic run_to_halt(input int limit);
        @(negedge clk);
        run = 1'b1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (halted) break;
        end
    endtask

    task automatic finish_report();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run is one failed check and still reports
    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            n_fail++;
            $display("FAIL R9 watchdog: actual=%0d cycles expected=below %0d", cyc, WD_LIMIT);
            finish_report();
        end
    end

    // Side-port write aimed at the store's execute edge (sixth enabled edge)
    task automatic race_store(input logic [7:0] a, input logic [7:0] d);
        hold_reset();
        load_prog(128'h00100455_610C0123_FF000000_00000000);
        poke(8'h10, 8'h00);
        poke(8'h11, 8'h00);
        free_reset();
        @(negedge clk);
        run = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        dbg_we = 1'b1; dbg_addr = a; dbg_wdata = d;
        @(negedge clk);
        dbg_we = 1'b0;
        for (int i = 0; i < 100 && !halted; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] snap;
        logic [7:0]  rb;
        rst_n = 1'b0; run = 1'b0; dbg_we = 1'b0; dbg_addr = '0; dbg_wdata = '0;
        repeat (2) @(negedge clk);
        check("R1 reset clears registers", regs, 32'h0);
        check("R1 reset clears halt", {31'b0, halted}, 32'h0);

        // Table of programs walked by one loop
        for (int v = 0; v < NV; v++) begin
            hold_reset();
            load_prog(VECS[v].prog);
            free_reset();
            run_to_halt(400);
            check(vtag(v), regs, VECS[v].regs);
            check("R9 halt after jump past top", {31'b0, halted}, 32'h1);
        end

        // R1: reset after a halted run clears state and keeps the store
        hold_reset();
        free_reset();
        check("R1 registers cleared after run", regs, 32'h0);
        check("R1 halt cleared", {31'b0, halted}, 32'h0);
        peek(8'h00, rb);
        check("R1 store preserved", {24'h0, rb}, 32'h0000000C);
        peek(8'h01, rb);
        check("R11 side-port read", {24'h0, rb}, 32'h00000001);

        // R2 timing and R10 pause/resume on the squaring program
        hold_reset();
        load_prog(VECS[0].prog);
        free_reset();
        @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        check("R2 no result after fetch edge", regs, 32'h0);
        @(negedge clk);
        check("R2 R3 literal after second edge", regs, 32'h00000003);
        repeat (7) @(negedge clk);
        run = 1'b0;
        snap = regs;
        check("R10 state at pause point", snap, 32'h00003209);
        repeat (10) @(negedge clk);
        check("R10 registers frozen while paused", regs, snap);
        check("R10 no halt while paused", {31'b0, halted}, 32'h0);
        run_to_halt(400);
        check("R10 R12 resume completes", regs, 32'h01003251);

        // R9: one-byte ops at 254 and 255 run, then PC would pass 255
        hold_reset();
        load_prog(128'h00070C01_23FE0000_00000000_00000000);
        poke(8'hFE, 8'h80);
        poke(8'hFF, 8'h80);
        free_reset();
        run_to_halt(400);
        check("R9 R5 top ops executed", regs, 32'h0100001C);
        check("R9 halt past 255", {31'b0, halted}, 32'h1);
        repeat (20) @(negedge clk);
        check("R9 registers frozen after halt", regs, 32'h0100001C);
        check("R9 halt held", {31'b0, halted}, 32'h1);

        // R9: two-byte literal at 255 is not executed
        hold_reset();
        load_prog(128'h0C0123FF_00000000_00000000_00000000);
        poke(8'hFF, 8'h04);
        free_reset();
        run_to_halt(400);
        check("R9 wide op at 255 not executed", regs, 32'h01000000);
        check("R9 halt on wide op at 255", {31'b0, halted}, 32'h1);
        poke(8'hFE, 8'h00);
        poke(8'hFF, 8'h00);

        // R11: side-port write on the same edge as a store
        race_store(8'h10, 8'hAA);
        peek(8'h10, rb);
        check("R11 same address side port wins", {24'h0, rb}, 32'h000000AA);
        race_store(8'h11, 8'h77);
        peek(8'h10, rb);
        check("R11 R7 store lands beside side write", {24'h0, rb}, 32'h00000055);
        peek(8'h11, rb);
        check("R11 side write lands beside store", {24'h0, rb}, 32'h00000077);

        finish_report();
    end
endmodule